// File: doc/BRIEF.md
# TDM Time-Slot Switch

This block is a time-slot interchange for eight serial TDM streams. Each stream carries a 125 µs frame of 32 slots, and each slot holds eight bits sent MSB first. Every bit lasts `CLK_PER_BIT` clocks. A free-running counter sets the frame phase and pulses `frame_sync` on frame cycle 0. At the end of each slot, the bytes received on all inputs are written into a double-buffered data memory, one page per frame. Output slot `t` goes out during counter slot `t+1`, so the output frame lags the input frame by one slot.

A 256-entry connection memory is indexed by {output stream, output slot}. Each entry decides what its output slot carries:
- a switched input byte, with either the minimum-delay rule or the frame-integrity rule;
- a constant byte held in the entry;
- nothing, in which case the output enable is low.

An entry can also loop its output byte back into the matching input position of the data memory.

Within each slot, the switch fetches bytes on even clocks. A host reaches both memories on odd clocks, through an address register and a data register.

Top module: `tss_switch`

## Requirements
- R1: Cycle counter `c` (0..511 per frame) gives slot `c[8:4]` and bit `c[3:1]`. Input bits are sampled on odd `c`, MSB first. Output bits change only after odd cycles, so each bit is held for two clocks. Output slot `t` is sent during counter slot `t+1` mod 32. `frame_sync` is high only when `c` = 0.
- R2: An entry in switch mode (mode bits [9:8] = 00) sends input stream `payload[7:5]`, slot `payload[4:0]`. Several entries may name the same source; each of them gets that byte.
- R3: Switch-mode entries with bit 10 = 0 use minimum delay. Source slot `j` for output slot `t` is taken from the current frame when `j < t`, and from the previous frame when `j >= t`.
- R4: Switch-mode entries with bit 10 = 1 (frame integrity) always take the source from the previous input frame.
- R5: Mode 01 sends the entry's `payload[7:0]` as the slot byte.
- R6: Modes 10 and 11 hold `tdm_oe` low for the whole slot. `tdm_oe` changes only at slot boundaries. After reset every entry is in mode 10.
- R7: Bit 11 (loopback) writes the byte sent in output slot (o,t) into the data memory in place of input slot (o,t) of the same frame.
- R8: A host write with `host_sel` = 0 loads the address register from `wdata[8:0]`. Address bits are {stream[7:5], slot[4:0]}, and bit 8 selects the data memory. This write also starts a read into the data register. A write with `host_sel` = 1 loads the data register and writes the 12-bit entry to the connection memory, unless bit 8 is set. `host_rdata` shows the address register when `host_sel` = 0 and the data register when `host_sel` = 1.
- R9: A host read of the data memory returns the byte of the last complete input frame.
- R10: An accepted host write sets `host_busy`. Busy clears on the next odd-cycle grant. A write made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| tdm_in | input | 8 | serial input streams |
| tdm_out | output | 8 | serial output streams |
| tdm_oe | output | 8 | per-stream output enable |
| frame_sync | output | 1 | frame start pulse |
| host_wr | input | 1 | host write strobe |
| host_sel | input | 1 | 0 address register, 1 data register |
| host_wdata | input | 16 | host write data |
| host_rdata | output | 16 | selected register contents |
| host_busy | output | 1 | host access pending |

## Verification
The bench targets the slot-boundary delay cases:
- A minimum-delay source whose slot equals the output slot must come from the previous frame. An off-by-one arrival test would send the current frame's byte there instead.
- A source in slot 31 feeding output slot 0 exercises the same rule at the frame edge.
- Frame-integrity entries whose source precedes their output catch a design that ignores the mode bit, because it would return current-frame data.

Loopback is checked by reading the looped position from another output. A misplaced write path would return the serial input pattern instead of the constant.

A second host write issued while busy must leave the first value in place. A design that accepts writes while busy would overwrite it.

// File: rtl/tss_pkg.sv
// Shared types for the time-slot switch: connection entry layout and slot modes.
package tss_pkg;
    localparam int ENTRY_W = 12;

    typedef enum logic [1:0] {
        MODE_SWITCH = 2'b00,
        MODE_CONST  = 2'b01,
        MODE_OFF    = 2'b10,
        MODE_OFF_B  = 2'b11
    } slot_mode_e;

    typedef struct packed {
        logic       loop;
        logic       integ;
        slot_mode_e mode;
        logic [7:0] payload;
    } cm_entry_t;
endpackage

// File: rtl/tss_timebase.sv
// Free-running frame counter. Assumes the frame length is a power of two clocks;
// the counter wraps to zero at each frame start.
module tss_timebase #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          frame_sync
);
    // advance one step per clock, wrap at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign frame_sync = (cnt == '0);
endmodule

// File: rtl/tss_rx_deser.sv
// Serial-to-parallel conversion for all input streams. Shifts on each bit strobe;
// the assembled byte (seven stored bits plus the live one) is valid on the last bit strobe.
module tss_rx_deser #(
    parameter int STREAMS = 8,
    parameter int BYTE_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              shift_en,
    input  logic [STREAMS-1:0]                serial_in,
    output logic [STREAMS-1:0][BYTE_W-1:0]    byte_now
);
    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        logic [BYTE_W-2:0] sh;
        // collect bits MSB first
        always_ff @(posedge clk) begin
            if (!rst_n)        sh <= '0;
            else if (shift_en) sh <= {sh[BYTE_W-3:0], serial_in[g]};
        end
        assign byte_now[g] = {sh, serial_in[g]};
    end
endmodule

// File: rtl/tss_data_mem.sv
// Two-page data memory. All streams write their slot byte together into the page of
// the current frame; one combinational read port is shared by the switch and the host.
module tss_data_mem #(
    parameter int STREAMS = 8,
    parameter int SLOTS   = 32,
    parameter int BYTE_W  = 8,
    localparam int SW     = $clog2(STREAMS),
    localparam int TW     = $clog2(SLOTS),
    localparam int AW     = 1 + SW + TW
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           wpage,
    input  logic [TW-1:0]                  wslot,
    input  logic [STREAMS-1:0][BYTE_W-1:0] wbytes,
    input  logic [AW-1:0]                  raddr,
    output logic [BYTE_W-1:0]              rdata
);
    logic [BYTE_W-1:0] mem [2*STREAMS*SLOTS];

    // store one slot of every stream at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2*STREAMS*SLOTS; i++) mem[i] <= '0;
        end else if (we) begin
            for (int s = 0; s < STREAMS; s++)
                mem[{wpage, SW'(s), wslot}] <= wbytes[s];
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tss_conn_mem.sv
// Connection memory: one entry per output stream and slot. All entries reset to
// the disconnected mode. Single write port, single combinational read port.
module tss_conn_mem #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  tss_pkg::cm_entry_t  wentry,
    input  logic [AW-1:0]       raddr,
    output tss_pkg::cm_entry_t  rentry
);
    tss_pkg::cm_entry_t mem [DEPTH];

    // host updates, reset to disconnect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '{loop: 1'b0, integ: 1'b0, mode: tss_pkg::MODE_OFF, payload: 8'h00};
        end else if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign rentry = mem[raddr];
endmodule

// File: rtl/tss_tx_ser.sv
// Parallel-to-serial conversion and output enable for all output streams.
// Loads on the slot boundary strobe, otherwise shifts on each bit strobe.
module tss_tx_ser #(
    parameter int STREAMS = 8,
    parameter int BYTE_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic                           shift_en,
    input  logic [STREAMS-1:0][BYTE_W-1:0] load_bytes,
    input  logic [STREAMS-1:0]             load_oe,
    output logic [STREAMS-1:0]             ser_out,
    output logic [STREAMS-1:0]             ser_oe
);
    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        logic [BYTE_W-1:0] sh;
        // send MSB first, enable held for the slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh        <= '0;
                ser_oe[g] <= 1'b0;
            end else if (load) begin
                sh        <= load_bytes[g];
                ser_oe[g] <= load_oe[g];
            end else if (shift_en) begin
                sh        <= {sh[BYTE_W-2:0], 1'b0};
            end
        end
        assign ser_out[g] = sh[BYTE_W-1];
    end
endmodule

// File: rtl/tss_switch.sv
// Time-slot switch top. Even clocks of each slot fetch the next byte of one output
// stream; odd clocks serve the host. Assumes CLK_PER_BIT is a power of two >= 2 and
// CLK_PER_BIT*BYTE_W >= 2*STREAMS; payload width 8 holds stream and slot numbers.
module tss_switch #(
    parameter int STREAMS     = 8,
    parameter int SLOTS       = 32,
    parameter int BYTE_W      = 8,
    parameter int CLK_PER_BIT = 2,
    parameter int HOST_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STREAMS-1:0] tdm_in,
    output logic [STREAMS-1:0] tdm_out,
    output logic [STREAMS-1:0] tdm_oe,
    output logic               frame_sync,
    input  logic               host_wr,
    input  logic               host_sel,
    input  logic [HOST_W-1:0]  host_wdata,
    output logic [HOST_W-1:0]  host_rdata,
    output logic               host_busy
);
    import tss_pkg::*;

    localparam int SW  = $clog2(STREAMS);
    localparam int TW  = $clog2(SLOTS);
    localparam int BW  = $clog2(BYTE_W);
    localparam int PW  = $clog2(CLK_PER_BIT);
    localparam int CW  = TW + BW + PW;
    localparam int CAW = SW + TW;
    localparam int DAW = 1 + CAW;
    localparam int IW  = PW + BW - 1;

    logic [CW-1:0] cnt;
    logic [TW-1:0] slot;
    logic [BW-1:0] bitpos;
    logic [IW-1:0] sw_idx;
    logic          bit_end, slot_end, frame_end, sw_valid, host_phase;

    tss_timebase #(.CW(CW)) u_tb (.clk(clk), .rst_n(rst_n), .cnt(cnt), .frame_sync(frame_sync));

    assign slot       = cnt[CW-1 -: TW];
    assign bitpos     = cnt[PW +: BW];
    assign bit_end    = (cnt[PW-1:0] == PW'(CLK_PER_BIT - 1));
    assign slot_end   = bit_end && (bitpos == BW'(BYTE_W - 1));
    assign frame_end  = slot_end && (slot == TW'(SLOTS - 1));
    assign host_phase = cnt[0];
    assign sw_idx     = cnt[PW+BW-1:1];
    assign sw_valid   = !cnt[0] && (32'(sw_idx) < STREAMS);

    // write page flips at each frame boundary
    logic wpage;
    always_ff @(posedge clk) begin
        if (!rst_n)         wpage <= 1'b0;
        else if (frame_end) wpage <= ~wpage;
    end

    // host registers
    logic [DAW-1:0]     addr_q;
    cm_entry_t          data_q;
    logic               op_rd;

    // shared memory read ports
    logic [CAW-1:0]     cm_raddr;
    cm_entry_t          cm_rentry;
    logic [DAW-1:0]     dm_raddr;
    logic [BYTE_W-1:0]  dm_rdata;
    logic [SW-1:0]      sw_stream;
    logic [SW-1:0]      src_stream;
    logic [TW-1:0]      src_slot;
    logic               rd_page;

    assign sw_stream  = sw_idx[SW-1:0];
    assign cm_raddr   = host_phase ? addr_q[CAW-1:0] : {sw_stream, slot};
    assign src_stream = cm_rentry.payload[SW+TW-1:TW];
    assign src_slot   = cm_rentry.payload[TW-1:0];

    // page choice: integrity reads last frame; min delay reads current if arrived
    always_comb begin
        if (cm_rentry.integ)       rd_page = ~wpage;
        else if (src_slot < slot)  rd_page = wpage;
        else                       rd_page = ~wpage;
    end

    assign dm_raddr = host_phase ? {~wpage, addr_q[CAW-1:0]} : {rd_page, src_stream, src_slot};

    // staging of the byte each output stream sends in the next slot
    logic [STREAMS-1:0][BYTE_W-1:0] stage_byte;
    logic [STREAMS-1:0]             stage_oe;
    logic [STREAMS-1:0]             stage_loop;

    // fetch one output stream per even clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_byte <= '0;
            stage_oe   <= '0;
            stage_loop <= '0;
        end else if (sw_valid) begin
            stage_loop[sw_stream] <= cm_rentry.loop;
            case (cm_rentry.mode)
                MODE_SWITCH: begin
                    stage_byte[sw_stream] <= dm_rdata;
                    stage_oe[sw_stream]   <= 1'b1;
                end
                MODE_CONST: begin
                    stage_byte[sw_stream] <= cm_rentry.payload;
                    stage_oe[sw_stream]   <= 1'b1;
                end
                default: begin
                    stage_byte[sw_stream] <= '0;
                    stage_oe[sw_stream]   <= 1'b0;
                end
            endcase
        end
    end

    // receive side and data memory write with loopback override
    logic [STREAMS-1:0][BYTE_W-1:0] rx_bytes;
    logic [STREAMS-1:0][BYTE_W-1:0] dm_wbytes;

    tss_rx_deser #(.STREAMS(STREAMS), .BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_end),
        .serial_in(tdm_in), .byte_now(rx_bytes)
    );

    // pick the looped output byte or the received byte per stream
    always_comb begin
        for (int s = 0; s < STREAMS; s++)
            dm_wbytes[s] = stage_loop[s] ? stage_byte[s] : rx_bytes[s];
    end

    tss_data_mem #(.STREAMS(STREAMS), .SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_dm (
        .clk(clk), .rst_n(rst_n), .we(slot_end), .wpage(wpage), .wslot(slot),
        .wbytes(dm_wbytes), .raddr(dm_raddr), .rdata(dm_rdata)
    );

    // host access control
    logic cm_we;
    assign cm_we = host_busy && host_phase && !op_rd && !addr_q[DAW-1];

    tss_conn_mem #(.DEPTH(STREAMS*SLOTS)) u_cm (
        .clk(clk), .rst_n(rst_n), .we(cm_we), .waddr(addr_q[CAW-1:0]),
        .wentry(data_q), .raddr(cm_raddr), .rentry(cm_rentry)
    );

    // accept one request when idle, complete it on the next odd clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            data_q    <= '0;
            op_rd     <= 1'b0;
            host_busy <= 1'b0;
        end else if (!host_busy) begin
            if (host_wr) begin
                host_busy <= 1'b1;
                op_rd     <= !host_sel;
                if (host_sel) data_q <= host_wdata[ENTRY_W-1:0];
                else          addr_q <= host_wdata[DAW-1:0];
            end
        end else if (host_phase) begin
            host_busy <= 1'b0;
            if (op_rd) data_q <= addr_q[DAW-1] ? cm_entry_t'({{(ENTRY_W-BYTE_W){1'b0}}, dm_rdata}) : cm_rentry;
        end
    end

    // register readback
    assign host_rdata = host_sel ? HOST_W'(data_q) : HOST_W'(addr_q);

    tss_tx_ser #(.STREAMS(STREAMS), .BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(slot_end), .shift_en(bit_end),
        .load_bytes(stage_byte), .load_oe(stage_oe), .ser_out(tdm_out), .ser_oe(tdm_oe)
    );
endmodule

// File: rtl/tss_switch_chk.sv
// Protocol checker for tss_switch, attached by bind. Observes counter phase,
// host handshake and serial outputs.
module tss_switch_chk #(
    parameter int CW      = 9,
    parameter int LOW_W   = 4,
    parameter int STREAMS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW-1:0]      cnt,
    input logic               host_wr,
    input logic               host_busy,
    input logic [STREAMS-1:0] tdm_out,
    input logic [STREAMS-1:0] tdm_oe
);
    // R10: an idle write raises busy
    assert_busy_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_busy) |=> host_busy);

    // R10: a pending access finishes at the odd-clock grant
    assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && cnt[0]) |=> !host_busy);

    // R6: enables change only at slot boundaries
    assert_oe_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[LOW_W-1:0] != '0) |-> $stable(tdm_oe));

    // R1: every bit is held across two clocks
    assert_bit_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[0] |-> $stable(tdm_out));
endmodule

bind tss_switch tss_switch_chk #(.CW(CW), .LOW_W(PW+BW), .STREAMS(STREAMS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .host_wr(host_wr), .host_busy(host_busy),
    .tdm_out(tdm_out), .tdm_oe(tdm_oe)
);

// File: tb/tss_switch_tb.sv
// Self-checking bench: programs a table of connection entries, captures output frame 3,
// compares against a model of the requirements, then runs host and reset cases.
module tss_switch_tb;
    localparam int FRAME = 512;
    localparam int CAPF  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tdm_in = '0;
    logic [7:0]  tdm_out, tdm_oe;
    logic        frame_sync;
    logic        host_wr = 1'b0, host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_busy;

    int total = 0, bad = 0, n = 0;
    bit done = 0;
    logic [7:0] capb  [8][32];
    logic       capoe [8][32];

    always #2.5 clk = ~clk;

    tss_switch u_dut (.clk(clk), .rst_n(rst_n), .tdm_in(tdm_in), .tdm_out(tdm_out),
        .tdm_oe(tdm_oe), .frame_sync(frame_sync), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_busy(host_busy));

    // {out stream, out slot, loop, integ, mode, payload}
    localparam logic [19:0] VEC [11] = '{
        {3'd0, 5'd0,  1'b0, 1'b0, 2'b00, 8'h23},
        {3'd0, 5'd10, 1'b0, 1'b0, 2'b00, 8'h23},
        {3'd1, 5'd10, 1'b0, 1'b1, 2'b00, 8'h23},
        {3'd4, 5'd7,  1'b0, 1'b0, 2'b00, 8'h87},
        {3'd5, 5'd7,  1'b0, 1'b0, 2'b00, 8'h23},
        {3'd6, 5'd20, 1'b0, 1'b0, 2'b01, 8'h5A},
        {3'd7, 5'd31, 1'b0, 1'b0, 2'b10, 8'h00},
        {3'd2, 5'd5,  1'b1, 1'b0, 2'b01, 8'hA5},
        {3'd3, 5'd10, 1'b0, 1'b0, 2'b00, 8'h45},
        {3'd0, 5'd31, 1'b0, 1'b1, 2'b00, 8'hFF},
        {3'd7, 5'd0,  1'b0, 1'b0, 2'b00, 8'hFF}
    };

    function automatic logic [7:0] pat(int f, int s, int j);
        return 8'(f*101 + s*32 + j*7 + 3);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_op(logic sel, logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        while (host_busy) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n) n++;

    // drive inputs and capture outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int v, f, cs, b, ot, of;
            v = n % FRAME; f = n / FRAME; cs = v >> 4; b = (v >> 1) & 7;
            for (int s = 0; s < 8; s++) tdm_in[s] = pat(f, s, cs)[7-b];
            if (v % 2 == 1) begin
                ot = (cs + 31) % 32;
                of = (cs == 0) ? f - 1 : f;
                if (of == CAPF) begin
                    for (int o = 0; o < 8; o++) begin
                        capb[o][ot][7-b] = tdm_out[o];
                        if (b == 0) capoe[o][ot] = tdm_oe[o];
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset busy", host_busy, 0);
        chk("R6 reset oe", tdm_oe, 0);
        chk("R8 reset rdata", host_rdata, 0);
        rst_n = 1'b1;

        // program the table
        for (int i = 0; i < 11; i++) begin
            host_op(1'b0, 16'(VEC[i][19:12]));
            host_op(1'b1, 16'(VEC[i][11:0]));
        end

        // wait until output frame CAPF is fully captured
        while (n < (CAPF + 1) * FRAME + 20) @(negedge clk);

        // walk the table against the model
        for (int i = 0; i < 11; i++) begin
            int o, t, s, j, ev;
            o = VEC[i][19:17]; t = VEC[i][16:12];
            s = VEC[i][7:5];   j = VEC[i][4:0];
            case (VEC[i][9:8])
                2'b00: begin
                    if (s == 2 && j == 5)  ev = 8'hA5;                       // R7 loop source
                    else if (VEC[i][10])   ev = pat(CAPF - 1, s, j);         // R4
                    else if (j < t)        ev = pat(CAPF, s, j);             // R3 arrived
                    else                   ev = pat(CAPF - 1, s, j);         // R3 not yet
                    chk($sformatf("R2/R3/R4/R7 out %0d slot %0d", o, t), capb[o][t], ev);
                    chk($sformatf("R6 oe on %0d slot %0d", o, t), capoe[o][t], 1);
                end
                2'b01: begin
                    chk($sformatf("R5 const %0d slot %0d", o, t), capb[o][t], VEC[i][7:0]);
                    chk($sformatf("R6 oe on %0d slot %0d", o, t), capoe[o][t], 1);
                end
                default: chk($sformatf("R6 off %0d slot %0d", o, t), capoe[o][t], 0);
            endcase
        end
        chk("R6 reset entry off", capoe[5][1], 0);

        // frame pulse
        while (n % FRAME != 0) @(negedge clk);
        chk("R1 frame_sync at 0", frame_sync, 1);
        @(negedge clk);
        chk("R1 frame_sync after 0", frame_sync, 0);

        // host readback of an entry
        host_op(1'b0, 16'h00D4);
        host_sel = 1'b0; #1;
        chk("R8 addr readback", host_rdata, 16'h00D4);
        host_sel = 1'b1; #1;
        chk("R8 entry readback", host_rdata, 16'h015A);

        // second write during busy is dropped
        @(negedge clk);
        while (n % 2 != 0) @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 16'h0111;
        @(negedge clk);
        chk("R10 busy raised", host_busy, 1);
        host_wdata = 16'h0222;
        @(negedge clk);
        host_wr = 1'b0;
        host_op(1'b0, 16'h00D4);
        host_sel = 1'b1; #1;
        chk("R10 busy write ignored", host_rdata, 16'h0111);

        // data memory read returns the last complete frame
        while (n % FRAME != 200) @(negedge clk);
        host_op(1'b0, 16'h0123);
        host_sel = 1'b1; #1;
        chk("R9 data memory read", host_rdata, pat(n / FRAME - 1, 1, 3));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule